// File: doc/BRIEF.md
# Four-State Bus Cycle Sequencer

This block turns one transfer request into a complete bus cycle on a multiplexed address/data bus. The request carries an address, a memory-or-I/O select, a direction flag and write data. The block steps through four clock states: T1, T2, T3 and T4. When the addressed device is slow, it inserts wait states between T2 and T3.

In T1 the block places the address on the shared bus, pulses the latch enable, and sets the space-select line and the direction line. From T2 onward a read releases the bus so the device can drive it. A write keeps driving the bus, now with data, until T3 ends. The device's ready line is first sampled at the end of T2. While ready stays low, the block repeats wait states, and every strobe and the bus drive hold steady. Read data is taken from the bus at the end of T3. T4 drops every bus control, shows the result and pulses done.

The block accepts a request only while idle or during T4. A request present in T4 starts the next cycle with no idle gap between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: While rst_ni is low, and in idle afterwards, ale_o, rd_o, wr_o, den_o, ad_oe_o, mem_io_o, dt_r_o and done_o are all 0.
- R2: In T1 (the cycle after acceptance), ad_o carries the latched address, ad_oe_o=1 and ale_o=1, while rd_o, wr_o and den_o are 0. mem_io_o shows the select (1 = memory, 0 = I/O) and dt_r_o shows the direction (1 = write/transmit, 0 = read/receive).
- R3: From T2 through T3, including any wait states, den_o=1 and ale_o=0. A read has rd_o=1, wr_o=0 and ad_oe_o=0. A write has wr_o=1, rd_o=0 and ad_oe_o=1, with the write data zero-extended on ad_o.
- R4: ready_i is sampled at the end of T2 and at the end of each wait state. A low sample gives one more wait state. A high sample leads to T3. ready_i has no effect in T3.
- R5: For a read, rdata_o takes ad_i[DATA_W-1:0] at the end of T3 and holds it until the next read's T3. A write leaves rdata_o unchanged.
- R6: In T4, rd_o, wr_o, den_o, ale_o and ad_oe_o are 0 and done_o is 1. done_o lasts one clock.
- R7: With no wait states, done_o is high in the fourth cycle after acceptance. Each wait state adds one cycle.
- R8: req_i and the request fields are ignored during T1, T2, wait states and T3. The cycle keeps the values latched at acceptance.
- R9: A request present during T4 is accepted, and T1 of the new cycle follows immediately.
- R10: mem_io_o and dt_r_o stay constant from T1 through T4 of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| addr_i | input | ADDR_W | Request address |
| is_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| is_write_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data |
| ready_i | input | 1 | Device ready; low requests wait states |
| ad_i | input | ADDR_W | Bus value seen on the pins |
| ad_o | output | ADDR_W | Bus value driven |
| ad_oe_o | output | 1 | Bus drive enable (0 = high impedance) |
| ale_o | output | 1 | Address latch enable |
| mem_io_o | output | 1 | Space select |
| dt_r_o | output | 1 | Data direction |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| den_o | output | 1 | Data enable, active high |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock cycle-complete pulse |

## Verification
All outputs are decoded from registered state, so each one changes one clock after the edge that moves the state. T1 is visible one cycle after acceptance, T2 two cycles after, and T3 3+N cycles after for N wait states. done_o and the new rdata_o are due 4+N cycles after acceptance. The bench drives inputs and samples outputs on the falling edge, and it counts falling edges from acceptance so every check lands on its expected phase. ready_i is changed half a cycle before the edge that samples it. ad_i carries the correct read value only during T3, which shows the capture happens at the end of T3.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW   = 3'd3,
    S_T3   = 3'd4,
    S_T4   = 3'd5
  } bcs_state_e;
endpackage

// File: rtl/bcs_fsm.sv
`timescale 1ns/1ps
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ready_i,
  output bcs_state_e state_o,
  output logic       accept_o
);
  bcs_state_e state_q, state_d;

  assign accept_o = req_i && (state_q == S_IDLE || state_q == S_T4);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  state_d = req_i ? S_T1 : S_IDLE;
      S_T1:    state_d = S_T2;
      S_T2:    state_d = ready_i ? S_T3 : S_TW;
      S_TW:    state_d = ready_i ? S_T3 : S_TW;
      S_T3:    state_d = S_T4;
      S_T4:    state_d = req_i ? S_T1 : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_wait_on_low_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_T2 || state_q == S_TW) && !ready_i) |=> (state_q == S_TW));
  assert_t3_after_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_T2 || state_q == S_TW) && ready_i) |=> (state_q == S_T3));
  assert_t1_to_t2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T1) |=> (state_q == S_T2));
  assert_t4_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_T4) |=> (state_q == S_T1 || state_q == S_IDLE));
endmodule

// File: rtl/bcs_req_latch.sv
`timescale 1ns/1ps
module bcs_req_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_mem_i,
  input  logic              is_write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_mem_o,
  output logic              is_write_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      is_mem_o   <= 1'b0;
      is_write_o <= 1'b0;
      wdata_o    <= '0;
    end else if (accept_i) begin
      addr_o     <= addr_i;
      is_mem_o   <= is_mem_i;
      is_write_o <= is_write_i;
      wdata_o    <= wdata_i;
    end
  end

  assert_fields_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(addr_o) && $stable(is_write_o) && $stable(wdata_o)));
endmodule

// File: rtl/bcs_bus_drive.sv
`timescale 1ns/1ps
module bcs_bus_drive
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bcs_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_mem_i,
  input  logic              is_write_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              mem_io_o,
  output logic              dt_r_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              den_o,
  output logic              done_o
);
  logic busy, data_phase;

  assign busy       = (state_i != S_IDLE);
  assign data_phase = (state_i == S_T2) || (state_i == S_TW) || (state_i == S_T3);

  always_comb begin
    ad_o = '0;
    if (state_i == S_T1)            ad_o = addr_i;
    else if (data_phase && is_write_i) ad_o = ADDR_W'(wdata_i);
  end

  assign ad_oe_o  = (state_i == S_T1) || (data_phase && is_write_i);
  assign ale_o    = (state_i == S_T1);
  assign mem_io_o = busy && is_mem_i;
  assign dt_r_o   = busy && is_write_i;
  assign rd_o     = data_phase && !is_write_i;
  assign wr_o     = data_phase && is_write_i;
  assign den_o    = data_phase;
  assign done_o   = (state_i == S_T4);

  assert_ale_alone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (!rd_o && !wr_o && !den_o));
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  assert_done_one_clk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_lines_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_o || done_o) |-> ($stable(mem_io_o) && $stable(dt_r_o)));
endmodule

// File: rtl/bcs_capture.sv
`timescale 1ns/1ps
module bcs_capture
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bcs_state_e        state_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rdata_o <= '0;
    else if (state_i == S_T3 && !is_write_i)    rdata_o <= ad_i[DATA_W-1:0];
  end

  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != S_T3 || is_write_i) |=> $stable(rdata_o));
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_mem_i,
  input  logic              is_write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] ad_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              mem_io_o,
  output logic              dt_r_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              den_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bcs_state_e        state;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              is_mem_q, is_write_q;
  logic [DATA_W-1:0] wdata_q;

  bcs_fsm u_fsm (
    .clk_i, .rst_ni, .req_i, .ready_i,
    .state_o(state), .accept_o(accept)
  );

  bcs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni, .accept_i(accept),
    .addr_i, .is_mem_i, .is_write_i, .wdata_i,
    .addr_o(addr_q), .is_mem_o(is_mem_q), .is_write_o(is_write_q), .wdata_o(wdata_q)
  );

  bcs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk_i, .rst_ni, .state_i(state),
    .addr_i(addr_q), .is_mem_i(is_mem_q), .is_write_i(is_write_q), .wdata_i(wdata_q),
    .ad_o, .ad_oe_o, .ale_o, .mem_io_o, .dt_r_o, .rd_o, .wr_o, .den_o, .done_o
  );

  bcs_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .state_i(state), .is_write_i(is_write_q),
    .ad_i, .rdata_o
  );
endmodule

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          mem;
    logic          wr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rbus;
    logic [3:0]    waits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{20'h12345, 1'b1, 1'b0, 16'h0000, 16'hBEEF, 4'd0},
    '{20'hABCDE, 1'b0, 1'b1, 16'h5A5A, 16'h0000, 4'd0},
    '{20'h00F0F, 1'b1, 1'b1, 16'hC3C3, 16'h0000, 4'd2},
    '{20'hFFFFF, 1'b0, 1'b0, 16'h0000, 16'h1234, 4'd3},
    '{20'h80001, 1'b1, 1'b0, 16'h0000, 16'h8001, 4'd1},
    '{20'h00000, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 4'd5}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, is_mem = 1'b0, is_wr = 1'b0, ready = 1'b1;
  logic [AW-1:0] addr = '0, ad_in = '0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] ad_o;
  logic ad_oe, ale, mem_io, dt_r, rd, wr, den, done;
  logic [DW-1:0] rdata;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] last_rd = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni, .req_i(req), .addr_i(addr), .is_mem_i(is_mem),
    .is_write_i(is_wr), .wdata_i(wdata), .ready_i(ready), .ad_i(ad_in),
    .ad_o, .ad_oe_o(ad_oe), .ale_o(ale), .mem_io_o(mem_io), .dt_r_o(dt_r),
    .rd_o(rd), .wr_o(wr), .den_o(den), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic set_req(input vec_t v);
    req = 1'b1; addr = v.addr; is_mem = v.mem; is_wr = v.wr; wdata = v.wdata;
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 0);   chk({tag, " rd"}, rd, 0);
    chk({tag, " wr"}, wr, 0);     chk({tag, " den"}, den, 0);
    chk({tag, " oe"}, ad_oe, 0);  chk({tag, " mio"}, mem_io, 0);
    chk({tag, " dtr"}, dt_r, 0);  chk({tag, " done"}, done, 0);
  endtask

  task automatic chk_t1(input vec_t v);
    chk("R2 ad", ad_o, v.addr);  chk("R2 oe", ad_oe, 1);  chk("R2 ale", ale, 1);
    chk("R2 rd", rd, 0);         chk("R2 wr", wr, 0);     chk("R2 den", den, 0);
    chk("R2 mio", mem_io, v.mem); chk("R2 dtr", dt_r, v.wr); chk("R7 done early", done, 0);
  endtask

  task automatic chk_data(input vec_t v, input string ph);
    chk({"R3 den ", ph}, den, 1);      chk({"R3 ale ", ph}, ale, 0);
    chk({"R3 rd ", ph}, rd, !v.wr);    chk({"R3 wr ", ph}, wr, v.wr);
    chk({"R3 oe ", ph}, ad_oe, v.wr);
    if (v.wr) chk({"R3 wdata ", ph}, ad_o, {{(AW-DW){1'b0}}, v.wdata});
    chk({"R10 mio ", ph}, mem_io, v.mem); chk({"R10 dtr ", ph}, dt_r, v.wr);
    chk({"R7 done early ", ph}, done, 0);
  endtask

  task automatic chk_t4(input vec_t v);
    chk("R6 rd", rd, 0);   chk("R6 wr", wr, 0);   chk("R6 den", den, 0);
    chk("R6 ale", ale, 0); chk("R6 oe", ad_oe, 0); chk("R6 done", done, 1);
    chk("R10 mio t4", mem_io, v.mem); chk("R10 dtr t4", dt_r, v.wr);
    chk("R5 rdata", rdata, last_rd);
  endtask

  // Drives one cycle from acceptance to T4; leaves the bench at the T4 falling edge.
  task automatic run_vec(input vec_t v, input bit chain);
    int cyc;
    set_req(v); ready = 1'b1; ad_in = ~{{(AW-DW){1'b0}}, v.rbus};
    @(negedge clk); cyc = 1;
    chk_t1(v);
    // R8: fields change and req stays high during the cycle
    addr = ~v.addr; is_wr = ~v.wr; is_mem = ~v.mem; wdata = ~v.wdata;
    @(negedge clk); cyc++;
    chk_data(v, "T2");
    ready = (v.waits == 0);
    for (int i = 0; i < int'(v.waits); i++) begin
      @(negedge clk); cyc++;
      chk_data(v, "TW R4");
      ready = (i + 1 >= int'(v.waits));
    end
    @(negedge clk); cyc++;
    chk_data(v, "T3 R4");
    chk("R8 ad hold", ad_oe ? ad_o : v.addr, v.wr ? {{(AW-DW){1'b0}}, v.wdata} : v.addr);
    ready = 1'b0;                       // R4: no effect in T3
    ad_in = {{(AW-DW){1'b0}}, v.rbus};  // correct data only in T3
    if (!chain) req = 1'b0;
    @(negedge clk); cyc++;
    if (!v.wr) last_rd = v.rbus;
    chk_t4(v);
    chk("R7 cycles to done", cyc, 4 + int'(v.waits));
    ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 20000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle");
    chk("R1 rdata", rdata, 0);

    for (int k = 0; k < NV; k++) begin
      run_vec(VECS[k], 1'b0);
      @(negedge clk);
      chk("R6 done one clk", done, 0);
      chk_idle("R1 after cycle");
    end

    // R9: back-to-back, second request presented during T4
    run_vec(VECS[0], 1'b1);
    set_req(VECS[1]);
    @(negedge clk);
    chk("R9 ale", ale, 1);
    chk("R9 ad", ad_o, VECS[1].addr);
    chk("R9 dtr", dt_r, 1);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 done second", done, 1);
    chk("R5 write keeps rdata", rdata, 16'hBEEF);
    @(negedge clk);

    // R1: asynchronous reset in the middle of T2
    set_req(VECS[2]);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk("R3 pre-reset den", den, 1);
    #1 rst_ni = 1'b0;
    #0.5;
    chk_idle("R1 async");
    chk("R1 rdata cleared", rdata, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    summary();
  end
endmodule